// File: doc/BRIEF.md
# Pipelined 18x18 Multiplier Cell with Operand Cascade

This block multiplies two 18-bit operands and returns the full 36-bit product. Each operand passes through an optional capture register. That register loads either from the cell's own parallel data port or from a cascade input, which is normally wired to the cascade output of the neighbouring cell. A row of cells wired this way forms a tapped delay line: one sample stream enters the first cell and moves one cell further on each enabled clock, while each cell multiplies its tap by a local coefficient. This is the usual structure of a direct-form FIR filter. The cell does not sum the products of neighbouring cells.

A per-operand control selects two's-complement or unsigned interpretation. Each control passes through the same optional register as its operand, so a control always applies to the operand sample it arrived with. The product then goes through an optional result register. Two parameters choose between a latency of 0, 1 or 2 clocks. A single clock enable holds every stage, and a synchronous active-high reset clears every stage.

Top module: `shiftmul_cell`

## Requirements
- R1: With both sign controls low, `product` equals the unsigned product of the two 18-bit operands over the full 36 bits. The largest case is 0x3FFFF times 0x3FFFF.
- R2: A sign control that is high makes its operand two's complement. A sign control that is low makes its operand unsigned. The 36-bit result is the correctly signed or zero-extended product for every mix of the two controls.
- R3: When `a_src` (or `b_src`) is 1, the operand register loads from `a_shin` (or `b_shin`) and ignores the parallel port. When it is 0, the register loads from `a_par` (or `b_par`).
- R4: `a_shout` and `b_shout` carry the value held in each operand register. In a chain, the second cell's operand therefore trails the first cell's operand by one enabled clock.
- R5: A sign control is captured in the same clock edge as the operand it goes with. A control change that arrives together with a new operand applies to that operand's product only.
- R6: With the default parameters (IN_REG=1, OUT_REG=1), the product of operands presented before edge k appears at `product` after edge k+1, and not after edge k.
- R7: While `ce` is low, the operand registers, the sign registers and the result register all keep their values, whatever the data and control inputs do.
- R8: A clock edge with `rst` high clears the operand, sign and result registers to zero. `product`, `a_shout` and `b_shout` read 0 after that edge.
- R9: With IN_REG=0 and OUT_REG=0, the cell is purely combinational, and `product` follows its inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear of all stages |
| ce | input | 1 | Clock enable shared by every stage |
| a_par | input | W | Parallel data for operand A |
| a_shin | input | W | Cascade input for operand A |
| a_src | input | 1 | Operand A source: 0 parallel, 1 cascade |
| a_signed | input | 1 | 1: operand A is two's complement |
| b_par | input | W | Parallel data for operand B |
| b_shin | input | W | Cascade input for operand B |
| b_src | input | 1 | Operand B source: 0 parallel, 1 cascade |
| b_signed | input | 1 | 1: operand B is two's complement |
| a_shout | output | W | Current operand A value, for the next cell |
| b_shout | output | W | Current operand B value, for the next cell |
| product | output | 2*W | Full-width product |

## Verification
Two functions can land on the same clock edge. One is a change of a sign control. The other is the move of a new operand through the input stage, while the result register is still finishing the product of the older operand. The bench provokes this by keeping operand A at the same bit pattern (0x3FFFF) and flipping its sign control from signed to unsigned between two consecutive edges. It then checks that the outputs read -2 and then 524286, in that order. A second collision comes from the cascade: the first cell loads a new sample on the same edge on which the second cell takes the first cell's old value. The bench checks the second cell's tap and product at each step, while a contradicting value sits on that cell's parallel port.

// File: rtl/shiftmul_pkg.sv
package shiftmul_pkg;

  // Where an operand register takes its next value from
  typedef enum logic {
    SRC_PARALLEL = 1'b0,
    SRC_CASCADE  = 1'b1
  } opsrc_e;

endpackage

// File: rtl/shiftmul_operand.sv
module shiftmul_operand
  import shiftmul_pkg::*;
#(
  parameter int W   = 18,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  opsrc_e       src,
  input  logic [W-1:0] par_d,
  input  logic [W-1:0] casc_d,
  input  logic         sign_d,
  output logic [W-1:0] val,
  output logic         sign_q,
  output logic [W-1:0] casc_q
);

  logic [W-1:0] next_val;

  assign next_val = (src == SRC_CASCADE) ? casc_d : par_d;

  generate
    if (REG) begin : g_reg
      logic [W-1:0] val_r;
      logic         sign_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          val_r  <= '0;
          sign_r <= 1'b0;
        end else if (ce) begin
          val_r  <= next_val;
          sign_r <= sign_d;
        end
      end
      assign val    = val_r;
      assign sign_q = sign_r;
    end else begin : g_comb
      assign val    = next_val;
      assign sign_q = sign_d;
    end
  endgenerate

  // The cascade output mirrors whatever feeds the multiplier
  assign casc_q = val;

endmodule

// File: rtl/shiftmul_core.sv
module shiftmul_core #(
  parameter int W = 18,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          a_sgn,
  input  logic          b_sgn,
  output logic [PW-1:0] p
);

  logic signed [W:0]    a_ext;
  logic signed [W:0]    b_ext;
  logic signed [PW+1:0] full;

  // One extra bit per operand turns a mixed signed/unsigned multiply
  // into a single signed one
  assign a_ext = $signed({a_sgn & a[W-1], a});
  assign b_ext = $signed({b_sgn & b[W-1], b});
  assign full  = a_ext * b_ext;
  assign p     = full[PW-1:0];

endmodule

// File: rtl/shiftmul_result.sv
module shiftmul_result #(
  parameter int PW  = 36,
  parameter bit REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] q
);

  generate
    if (REG) begin : g_reg
      logic [PW-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end
      assign q = q_r;
    end else begin : g_comb
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/shiftmul_cell.sv
module shiftmul_cell
  import shiftmul_pkg::*;
#(
  parameter int W       = 18,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [W-1:0]  a_par,
  input  logic [W-1:0]  a_shin,
  input  logic          a_src,
  input  logic          a_signed,
  input  logic [W-1:0]  b_par,
  input  logic [W-1:0]  b_shin,
  input  logic          b_src,
  input  logic          b_signed,
  output logic [W-1:0]  a_shout,
  output logic [W-1:0]  b_shout,
  output logic [PW-1:0] product
);

  logic [W-1:0]  a_val;
  logic [W-1:0]  b_val;
  logic          sa_q;
  logic          sb_q;
  logic [PW-1:0] raw_p;

  shiftmul_operand #(.W(W), .REG(IN_REG)) u_opa (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .src    (opsrc_e'(a_src)),
    .par_d  (a_par),
    .casc_d (a_shin),
    .sign_d (a_signed),
    .val    (a_val),
    .sign_q (sa_q),
    .casc_q (a_shout)
  );

  shiftmul_operand #(.W(W), .REG(IN_REG)) u_opb (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .src    (opsrc_e'(b_src)),
    .par_d  (b_par),
    .casc_d (b_shin),
    .sign_d (b_signed),
    .val    (b_val),
    .sign_q (sb_q),
    .casc_q (b_shout)
  );

  shiftmul_core #(.W(W)) u_core (
    .a     (a_val),
    .b     (b_val),
    .a_sgn (sa_q),
    .b_sgn (sb_q),
    .p     (raw_p)
  );

  shiftmul_result #(.PW(PW), .REG(OUT_REG)) u_res (
    .clk (clk),
    .rst (rst),
    .ce  (ce),
    .d   (raw_p),
    .q   (product)
  );

endmodule

// File: rtl/shiftmul_chk.sv
module shiftmul_chk #(
  parameter int W       = 18,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int PW = 2 * W
) (
  input logic          clk,
  input logic          rst,
  input logic          ce,
  input logic [W-1:0]  a_par,
  input logic [W-1:0]  a_shin,
  input logic          a_src,
  input logic [W-1:0]  b_par,
  input logic [W-1:0]  b_shin,
  input logic          b_src,
  input logic [W-1:0]  a_shout,
  input logic [W-1:0]  b_shout,
  input logic          sa_q,
  input logic          sb_q,
  input logic [PW-1:0] product
);

  // Independent product reference: 64-bit signed arithmetic
  longint        ref_a;
  longint        ref_b;
  logic [PW-1:0] ref_p;

  always_comb begin
    ref_a = sa_q ? longint'($signed(a_shout)) : longint'({46'd0, a_shout});
    ref_b = sb_q ? longint'($signed(b_shout)) : longint'({46'd0, b_shout});
    ref_p = PW'(ref_a * ref_b);
  end

  generate
    if (IN_REG) begin : g_in
      p_clear_ops_r8: assert property (@(posedge clk)
        rst |=> (a_shout == '0 && b_shout == '0));
      p_hold_ops_r7: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(a_shout) && $stable(b_shout)));
      p_cascade_load_r3: assert property (@(posedge clk) disable iff (rst)
        (ce && a_src) |=> (a_shout == $past(a_shin)));
      p_parallel_load_r3: assert property (@(posedge clk) disable iff (rst)
        (ce && !b_src) |=> (b_shout == $past(b_par)));
    end
    if (OUT_REG) begin : g_out
      p_clear_result_r8: assert property (@(posedge clk)
        rst |=> (product == '0));
      p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(product));
      p_product_value_r2: assert property (@(posedge clk) disable iff (rst)
        ce |=> (product == $past(ref_p)));
    end
  endgenerate

endmodule

bind shiftmul_cell shiftmul_chk #(.W(W), .IN_REG(IN_REG), .OUT_REG(OUT_REG)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .a_par   (a_par),
  .a_shin  (a_shin),
  .a_src   (a_src),
  .b_par   (b_par),
  .b_shin  (b_shin),
  .b_src   (b_src),
  .a_shout (a_shout),
  .b_shout (b_shout),
  .sa_q    (sa_q),
  .sb_q    (sb_q),
  .product (product)
);

// File: tb/test_shiftmul_cell.sv
module test_shiftmul_cell;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 18;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce  = 1'b1;

  logic [W-1:0]  a0 = '0, b0 = '0, a1 = '0, b1 = '0, a2 = '0, b2 = '0;
  logic          sa0 = 0, sb0 = 0, sa1 = 0, sb1 = 0, sa2 = 0, sb2 = 0;
  logic          src_a1 = 1'b0;
  logic [W-1:0]  a0_sh, b0_sh, a1_sh, b1_sh, a2_sh, b2_sh;
  logic [PW-1:0] p0, p1, p2;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // First cell: parallel operands
  shiftmul_cell i_shiftmul_cell (
    .clk(clk), .rst(rst), .ce(ce),
    .a_par(a0), .a_shin('0), .a_src(1'b0), .a_signed(sa0),
    .b_par(b0), .b_shin('0), .b_src(1'b0), .b_signed(sb0),
    .a_shout(a0_sh), .b_shout(b0_sh), .product(p0)
  );

  // Second cell: operand A taken from the first cell's cascade output
  shiftmul_cell i_shiftmul_cell_tap (
    .clk(clk), .rst(rst), .ce(ce),
    .a_par(a1), .a_shin(a0_sh), .a_src(src_a1), .a_signed(sa1),
    .b_par(b1), .b_shin(b0_sh), .b_src(1'b0), .b_signed(sb1),
    .a_shout(a1_sh), .b_shout(b1_sh), .product(p1)
  );

  // Fully combinational variant
  shiftmul_cell #(.IN_REG(1'b0), .OUT_REG(1'b0)) i_shiftmul_cell_comb (
    .clk(clk), .rst(rst), .ce(ce),
    .a_par(a2), .a_shin('0), .a_src(1'b0), .a_signed(sa2),
    .b_par(b2), .b_shin('0), .b_src(1'b0), .b_signed(sb2),
    .a_shout(a2_sh), .b_shout(b2_sh), .product(p2)
  );

  function automatic logic [PW-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic sa, input logic sb);
    longint ea = sa ? longint'($signed(a)) : longint'({46'd0, a});
    longint eb = sb ? longint'($signed(b)) : longint'({46'd0, b});
    return PW'(ea * eb);
  endfunction

  task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive0(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic sa, input logic sb);
    a0 = a; b0 = b; sa0 = sa; sb0 = sb;
  endtask

  task automatic t_reset();
    rst = 1'b1; ce = 1'b1;
    drive0(18'h1234, 18'h0777, 1'b0, 1'b0);
    tick(); tick();
    check("R8 product cleared", p0, '0);
    check("R8 a_shout cleared", PW'(a0_sh), '0);
    check("R8 tap product cleared", p1, '0);
    rst = 1'b0;
  endtask

  task automatic t_unsigned();
    drive0(18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0);
    tick();
    check("R6 not ready after one edge", p0, model(18'h1234, 18'h0777, 0, 0) & '0);
    tick();
    check("R1 max unsigned", p0, 36'hFFFF80001);
    check("R6 ready after two edges", p0, model(18'h3FFFF, 18'h3FFFF, 0, 0));
    drive0(18'd12345, 18'd678, 1'b0, 1'b0);
    tick(); tick();
    check("R1 unsigned mid", p0, 36'd8369910);
  endtask

  task automatic t_signed();
    drive0(18'h3FFFB, 18'd7, 1'b1, 1'b0);
    tick(); tick();
    check("R2 signed x unsigned", p0, model(18'h3FFFB, 18'd7, 1, 0));
    drive0(18'h20000, 18'h20000, 1'b1, 1'b1);
    tick(); tick();
    check("R2 min x min", p0, 36'h400000000);
    drive0(18'h3FFFF, 18'h3FFFF, 1'b1, 1'b0);
    tick(); tick();
    check("R2 -1 x unsigned max", p0, model(18'h3FFFF, 18'h3FFFF, 1, 0));
    drive0(18'd9, 18'h3FFFD, 1'b0, 1'b1);
    tick(); tick();
    check("R2 unsigned x signed", p0, model(18'd9, 18'h3FFFD, 0, 1));
  endtask

  task automatic t_sign_align();
    drive0(18'h3FFFF, 18'd2, 1'b1, 1'b0);
    tick();
    sa0 = 1'b0;
    tick();
    check("R5 first sample signed", p0, {PW{1'b1}} - 36'd1);
    tick();
    check("R5 second sample unsigned", p0, 36'd524286);
  endtask

  task automatic t_freeze();
    drive0(18'd100, 18'd200, 1'b0, 1'b0);
    tick(); tick();
    check("R7 before hold", p0, 36'd20000);
    ce = 1'b0;
    drive0(18'd7, 18'd9, 1'b1, 1'b1);
    tick(); tick(); tick();
    check("R7 product held", p0, 36'd20000);
    check("R7 operand held", PW'(a0_sh), 36'd100);
    ce = 1'b1;
    tick();
    check("R7 resume first edge", p0, 36'd20000);
    tick();
    check("R7 resume second edge", p0, 36'd63);
  endtask

  task automatic t_chain();
    src_a1 = 1'b1; a1 = 18'h2AAAA; b1 = 18'd3; sa1 = 0; sb1 = 0; sa0 = 0;
    a0 = 18'd10; tick();
    check("R4 first cell tap", PW'(a0_sh), 36'd10);
    a0 = 18'd20; tick();
    check("R4 second cell trails", PW'(a1_sh), 36'd10);
    check("R3 cascade ignores parallel", PW'(a1_sh), 36'd10);
    a0 = 18'd30; tick();
    check("R4 second cell step", PW'(a1_sh), 36'd20);
    check("R3 chained product", p1, 36'd30);
    tick();
    check("R3 chained product next", p1, 36'd60);
    src_a1 = 1'b0; a1 = 18'd55; tick();
    check("R3 parallel select", PW'(a1_sh), 36'd55);
  endtask

  task automatic t_bypass();
    a2 = 18'h3FFFD; b2 = 18'd4; sa2 = 1; sb2 = 1; #1;
    check("R9 combinational signed", p2, model(18'h3FFFD, 18'd4, 1, 1));
    sa2 = 0; #1;
    check("R9 combinational unsigned", p2, model(18'h3FFFD, 18'd4, 0, 1));
    a2 = 18'd1000; b2 = 18'd1000; sb2 = 0; #1;
    check("R9 follows input", p2, 36'd1000000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unsigned();
    t_signed();
    t_sign_align();
    t_freeze();
    t_chain();
    t_bypass();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule